// File: doc/BRIEF.md
# Address-Routed Serial Control Slave

This block is a three-wire synchronous slave. The host controls it with an enable line, a serial clock and a serial data input. The block also has a data-out line that it can tri-state. Every transfer starts with four address bits. The address sets how long the payload is, whether the transfer writes or reads, and, for a write, which of two stored control words receives the payload. A write is committed only when the enable line is released, and only if the payload length exactly matches what the address calls for.

One address selects read mode. In read mode the data-out line returns a snapshot of a 20-bit frequency count, followed by the overflow flag, the busy flag and two general-purpose port levels. A control bit in the active word can turn the data-out line into a continuous, inverted counter-busy indicator. A select input picks which of the two stored words drives the configuration outputs. The serial lines are oversampled by the system clock through a synchronizer, and edges are detected after the synchronizer.

Top module: `ser_ctrl_slave`

## Requirements
- R1: After reset both stored words are all zero. This clears the busy-output bit (36), the oscillator select bits (32, 33), the oscillator output enable (34), the test bits (38, 39) and the port direction bits (24, 25), which leaves both ports as inputs. `ser_dout_en` is low.
- R2: While `ser_en` is high, every rising edge of `ser_clk` samples one bit of `ser_din`. The first four bits are the address, sent A0 first. The payload follows, and payload bit k lands in bit k of the destination word.
- R3: With A0=0, the pair (A2,A3) sets the payload length: (0,1) means 24 bits, (1,0) means 32 bits and (1,1) means 40 bits. A commit replaces only the low bits up to that length and keeps the upper bits of the word.
- R4: A1=0 routes a write to word 1. A1=1 routes it to word 2.
- R5: A write commits on the falling edge of `ser_en`, and only if the number of payload bits equals the length set by the address. Frames that are short, long or carry an invalid address leave both words unchanged.
- R6: `ctrl_word` shows word 1 when `bank_sel` is 0 and word 2 when `bank_sel` is 1.
- R7: Address (A0..A3)=(1,0,0,0) starts a read and enables `ser_dout`. Once the fourth rising edge has passed, `ser_dout` carries count bit 0. Each further rising edge advances by one bit, giving the count LSB first, then overflow, busy, `gpio_level[0]` and `gpio_level[1]`.
- R8: A read ends when `ser_en` falls. Each read captures a fresh snapshot, so reads that follow one another each return the current inputs.
- R9: When bit 36 of `ctrl_word` is 1, `ser_dout_en` is high outside reads and `ser_dout` equals the inverse of `ifc_busy`. An active read takes priority over this output.
- R10: Outside a read, with bit 36 clear, `ser_dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Transfer enable; a frame spans its high time |
| ser_clk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| ser_din | input | 1 | Serial data in: address, then payload |
| bank_sel | input | 1 | Selects which stored word drives `ctrl_word` |
| ifc_count | input | CNT_W | Frequency count value returned by reads |
| ifc_over | input | 1 | Count overflow flag |
| ifc_busy | input | 1 | Counter busy flag |
| gpio_level | input | PORT_N | Levels of the general-purpose ports |
| ser_dout | output | 1 | Serial data out value |
| ser_dout_en | output | 1 | Output enable for `ser_dout`; low means high impedance |
| ctrl_word | output | MAX_LEN | Active configuration word |

## Verification
The assertions check on every cycle that the stored words change only right after an enable fall, and that `ctrl_word` holds steady unless the select or a commit moves it. They also check that a read ends only at an enable fall, that the output is driven during reads and in busy mode, and that in busy mode the output is the inverse of busy. Some behaviour can only be shown by the bench's scenarios: the bit ordering, length-dependent merging, routing by A1, the rejection of short, long and invalid frames, and the exact serial read stream of back-to-back reads.

// File: rtl/ser_ctrl_pkg.sv
package ser_ctrl_pkg;
   localparam int unsigned ADDR_BITS = 4;
   localparam int unsigned NUM_BANKS = 2;
   localparam int unsigned LEN_FREQ  = 24;
   localparam int unsigned LEN_BAND  = 32;
   localparam int unsigned LEN_INIT  = 40;
   // address vector: bit i holds Ai; read pattern A0=1, A1..A3=0
   localparam logic [ADDR_BITS-1:0] RD_CODE = 4'b0001;

   // payload length expected for a write address, 0 when not a write
   function automatic int unsigned frame_len(input logic [ADDR_BITS-1:0] a);
      if (a[0]) return 0;
      case (a[3:2])
         2'b10:   return LEN_FREQ;
         2'b01:   return LEN_BAND;
         2'b11:   return LEN_INIT;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/ser_ctrl_sync.sv
module ser_ctrl_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/ser_ctrl_rx.sv
module ser_ctrl_rx
   import ser_ctrl_pkg::*;
#(
   parameter int unsigned MAX_LEN = 40,
   parameter int unsigned BCNT_W  = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en_s,
   input  logic                 clk_s,
   input  logic                 din_s,
   output logic [ADDR_BITS-1:0] addr,
   output logic [MAX_LEN-1:0]   pay,
   output logic [BCNT_W-1:0]    bcnt,
   output logic                 frame_end,
   output logic                 rd_start,
   output logic                 bit_rise
);
   localparam logic [BCNT_W-1:0] CNT_MAX = '1;
   localparam logic [BCNT_W-1:0] A_NUM   = BCNT_W'(ADDR_BITS);
   localparam logic [BCNT_W-1:0] A_LAST  = BCNT_W'(ADDR_BITS - 1);
   localparam logic [BCNT_W-1:0] P_NUM   = BCNT_W'(MAX_LEN);
   localparam int unsigned       AIDX_W  = $clog2(ADDR_BITS);

   logic              en_d, clk_d;
   logic [BCNT_W-1:0] pidx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_d  <= 1'b0;
         clk_d <= 1'b0;
      end else begin
         en_d  <= en_s;
         clk_d <= clk_s;
      end
   end

   assign bit_rise  = en_s & clk_s & ~clk_d;
   assign frame_end = en_d & ~en_s;
   assign pidx      = bcnt - A_NUM;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt <= '0;
         addr <= '0;
         pay  <= '0;
      end else if (!en_s) begin
         bcnt <= '0;
      end else if (bit_rise) begin
         if (bcnt < A_NUM)      addr[bcnt[AIDX_W-1:0]] <= din_s;
         else if (pidx < P_NUM) pay[pidx]              <= din_s;
         if (bcnt != CNT_MAX)   bcnt <= bcnt + 1'b1;
      end
   end

   assign rd_start = bit_rise && (bcnt == A_LAST) &&
                     ({din_s, addr[ADDR_BITS-2:0]} == RD_CODE);
endmodule

// File: rtl/ser_ctrl_bank.sv
module ser_ctrl_bank
   import ser_ctrl_pkg::*;
#(
   parameter int unsigned MAX_LEN = 40,
   parameter int unsigned BCNT_W  = 6
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                frame_end,
   input  logic [ADDR_BITS-1:0]                addr,
   input  logic [MAX_LEN-1:0]                  pay,
   input  logic [BCNT_W-1:0]                   bcnt,
   input  logic                                bank_sel,
   output logic [NUM_BANKS-1:0][MAX_LEN-1:0]   bank_q,
   output logic [MAX_LEN-1:0]                  ctrl_word
);
   int unsigned        want;
   logic [BCNT_W-1:0]  got;
   logic               commit;
   logic [MAX_LEN-1:0] mask;

   always_comb begin
      want   = frame_len(addr);
      got    = bcnt - BCNT_W'(ADDR_BITS);
      commit = frame_end && (want != 0) && (32'(got) == want);
      for (int unsigned i = 0; i < MAX_LEN; i++) mask[i] = (i < want);
   end

   for (genvar g = 0; g < int'(NUM_BANKS); g++) begin : g_bank
      logic [MAX_LEN-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (commit && (addr[1] == 1'(g)))
            q <= (q & ~mask) | (pay & mask);
      end
      assign bank_q[g] = q;
   end

   assign ctrl_word = bank_q[bank_sel];
endmodule

// File: rtl/ser_ctrl_tx.sv
module ser_ctrl_tx #(
   parameter int unsigned RD_W = 24
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_start,
   input  logic            bit_rise,
   input  logic            frame_end,
   input  logic [RD_W-1:0] snap,
   output logic            rd_active,
   output logic            bit_out
);
   logic [RD_W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh        <= '0;
         rd_active <= 1'b0;
      end else if (rd_start) begin
         sh        <= snap;
         rd_active <= 1'b1;
      end else if (frame_end) begin
         rd_active <= 1'b0;
      end else if (rd_active && bit_rise) begin
         sh <= sh >> 1;
      end
   end

   assign bit_out = sh[0];
endmodule

// File: rtl/ser_ctrl_slave.sv
module ser_ctrl_slave
   import ser_ctrl_pkg::*;
#(
   parameter int unsigned MAX_LEN     = 40,
   parameter int unsigned CNT_W       = 20,
   parameter int unsigned PORT_N      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DOC_BIT     = 36
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_en,
   input  logic               ser_clk,
   input  logic               ser_din,
   input  logic               bank_sel,
   input  logic [CNT_W-1:0]   ifc_count,
   input  logic               ifc_over,
   input  logic               ifc_busy,
   input  logic [PORT_N-1:0]  gpio_level,
   output logic               ser_dout,
   output logic               ser_dout_en,
   output logic [MAX_LEN-1:0] ctrl_word
);
   localparam int unsigned BCNT_W = $clog2(ADDR_BITS + MAX_LEN + 2);
   localparam int unsigned RD_W   = CNT_W + 2 + PORT_N;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $fatal(1, "SYNC_STAGES must be at least 2");
   end
   if (MAX_LEN < LEN_INIT) begin : g_bad_len
      $fatal(1, "MAX_LEN must hold the longest payload");
   end
   if (DOC_BIT >= MAX_LEN) begin : g_bad_doc
      $fatal(1, "DOC_BIT must lie inside the control word");
   end

   logic [2:0]                        sync_q;
   logic [ADDR_BITS-1:0]              addr;
   logic [MAX_LEN-1:0]                pay;
   logic [BCNT_W-1:0]                 bcnt;
   logic                              frame_end, rd_start, bit_rise;
   logic                              rd_active, tx_bit;
   logic [NUM_BANKS-1:0][MAX_LEN-1:0] bank_q;
   logic                              busy_mode;

   ser_ctrl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n),
      .d({ser_en, ser_clk, ser_din}), .q(sync_q)
   );

   ser_ctrl_rx #(.MAX_LEN(MAX_LEN), .BCNT_W(BCNT_W)) i_rx (
      .clk(clk), .rst_n(rst_n),
      .en_s(sync_q[2]), .clk_s(sync_q[1]), .din_s(sync_q[0]),
      .addr(addr), .pay(pay), .bcnt(bcnt),
      .frame_end(frame_end), .rd_start(rd_start), .bit_rise(bit_rise)
   );

   ser_ctrl_bank #(.MAX_LEN(MAX_LEN), .BCNT_W(BCNT_W)) i_bank (
      .clk(clk), .rst_n(rst_n), .frame_end(frame_end),
      .addr(addr), .pay(pay), .bcnt(bcnt), .bank_sel(bank_sel),
      .bank_q(bank_q), .ctrl_word(ctrl_word)
   );

   ser_ctrl_tx #(.RD_W(RD_W)) i_tx (
      .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .bit_rise(bit_rise),
      .frame_end(frame_end),
      .snap({gpio_level, ifc_busy, ifc_over, ifc_count}),
      .rd_active(rd_active), .bit_out(tx_bit)
   );

   assign busy_mode   = ctrl_word[DOC_BIT];
   assign ser_dout_en = rd_active | busy_mode;
   assign ser_dout    = rd_active ? tx_bit : (busy_mode & ~ifc_busy);
endmodule

// File: rtl/ser_ctrl_chk.sv
module ser_ctrl_chk
   import ser_ctrl_pkg::*;
#(
   parameter int unsigned MAX_LEN = 40,
   parameter int unsigned DOC_BIT = 36
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              frame_end,
   input logic                              rd_active,
   input logic                              bank_sel,
   input logic                              ser_dout,
   input logic                              ser_dout_en,
   input logic                              ifc_busy,
   input logic [MAX_LEN-1:0]                ctrl_word,
   input logic [NUM_BANKS-1:0][MAX_LEN-1:0] bank_q
);
   // R5
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> $stable(bank_q));

   // R6
   word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(bank_sel) && !$past(frame_end)) |-> $stable(ctrl_word));

   // R8
   rd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_active) |-> $past(frame_end));

   // R7
   rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_active |-> ser_dout_en);

   // R9
   busy_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_dout_en && !rd_active) |-> (ser_dout != ifc_busy));

   // R10
   idle_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_active && !ctrl_word[DOC_BIT]) |-> !ser_dout_en);
endmodule

bind ser_ctrl_slave ser_ctrl_chk #(.MAX_LEN(MAX_LEN), .DOC_BIT(DOC_BIT)) i_chk (
   .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .rd_active(rd_active),
   .bank_sel(bank_sel), .ser_dout(ser_dout), .ser_dout_en(ser_dout_en),
   .ifc_busy(ifc_busy), .ctrl_word(ctrl_word), .bank_q(bank_q)
);

// File: tb/test_ser_ctrl_slave.sv
module test_ser_ctrl_slave;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_en = 1'b0, ser_clk = 1'b0, ser_din = 1'b0, bank_sel = 1'b0;
   logic [19:0] ifc_count = '0;
   logic        ifc_over = 1'b0, ifc_busy = 1'b0;
   logic [1:0]  gpio_level = '0;
   logic        ser_dout, ser_dout_en;
   logic [39:0] ctrl_word;
   int          nchk = 0, nerr = 0;

   always #10 clk = ~clk;

   ser_ctrl_slave i_ser_ctrl_slave (
      .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
      .ser_din(ser_din), .bank_sel(bank_sel), .ifc_count(ifc_count),
      .ifc_over(ifc_over), .ifc_busy(ifc_busy), .gpio_level(gpio_level),
      .ser_dout(ser_dout), .ser_dout_en(ser_dout_en), .ctrl_word(ctrl_word)
   );

   typedef struct packed {
      logic [3:0]  addr;   // bit i = Ai
      logic [6:0]  nbits;
      logic [39:0] pay;
      logic        sel;
      logic [39:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{4'b1100, 7'd40, 40'h0A12345678, 1'b0, 40'h0A12345678, 4'd2},  // R2 40 bits to word 1
      '{4'b1110, 7'd40, 40'h0587654321, 1'b1, 40'h0587654321, 4'd4},  // R4 40 bits to word 2
      '{4'b1000, 7'd24, 40'h0000ABCDEF, 1'b0, 40'h0A12ABCDEF, 4'd3},  // R3 24-bit merge
      '{4'b0110, 7'd32, 40'h0011112222, 1'b1, 40'h0511112222, 4'd3},  // R3 32-bit merge
      '{4'b1000, 7'd23, 40'h000000FFFF, 1'b0, 40'h0A12ABCDEF, 4'd5},  // R5 short frame
      '{4'b0110, 7'd33, 40'h01FFFFFFFF, 1'b1, 40'h0511112222, 4'd5},  // R5 long frame
      '{4'b0000, 7'd24, 40'h0000123456, 1'b0, 40'h0A12ABCDEF, 4'd5},  // R5 invalid address
      '{4'b1010, 7'd24, 40'h000000C0DE, 1'b1, 40'h051100C0DE, 4'd4}   // R4 24 bits to word 2
   };

   task automatic chk(input logic [39:0] act, input logic [39:0] exp, input string tag);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clock_bit(input logic b);
      ser_din = b;
      wait_clk(8);
      ser_clk = 1'b1;
      wait_clk(8);
      ser_clk = 1'b0;
   endtask

   task automatic send_frame(input logic [3:0] a, input int n, input logic [39:0] p);
      ser_en = 1'b1;
      wait_clk(8);
      for (int i = 0; i < 4; i++) clock_bit(a[i]);
      for (int i = 0; i < n; i++) clock_bit((i < 40) ? p[i] : 1'b0);
      wait_clk(8);
      ser_en = 1'b0;
      wait_clk(10);
   endtask

   // R7 stream check, R8 end of read
   task automatic do_read(input logic [19:0] c, input logic ov, input logic bz,
                          input logic [1:0] g, input logic idle_en);
      logic [23:0] exp;
      ifc_count = c; ifc_over = ov; ifc_busy = bz; gpio_level = g;
      exp = {g, bz, ov, c};
      ser_en = 1'b1;
      wait_clk(8);
      for (int i = 0; i < 4; i++) clock_bit((i == 0) ? 1'b1 : 1'b0);
      for (int i = 0; i < 24; i++) begin
         chk({39'b0, ser_dout_en}, 40'd1, "R7 dout enabled during read");
         chk({39'b0, ser_dout}, {39'b0, exp[i]}, $sformatf("R7 read bit %0d", i));
         clock_bit(1'b0);
      end
      wait_clk(8);
      ser_en = 1'b0;
      wait_clk(10);
      chk({39'b0, ser_dout_en}, {39'b0, idle_en}, "R8 dout enable after read end");
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      // R1 reset state of both words, R10 output released
      chk(ctrl_word, 40'h0, "R1 word 1 after reset");
      bank_sel = 1'b1; wait_clk(2);
      chk(ctrl_word, 40'h0, "R1 word 2 after reset");
      chk({39'b0, ser_dout_en}, 40'd0, "R10 dout idle after reset");

      // table walk: R2 R3 R4 R5 R6
      foreach (VECS[k]) begin
         send_frame(VECS[k].addr, int'(VECS[k].nbits), VECS[k].pay);
         bank_sel = VECS[k].sel;
         wait_clk(2);
         chk(ctrl_word, VECS[k].exp, $sformatf("R%0d vector %0d", VECS[k].req, k));
         chk({39'b0, ser_dout_en}, 40'd0, "R10 dout idle after write");
      end

      // R6 select flips between stored words
      bank_sel = 1'b0; wait_clk(2);
      chk(ctrl_word, 40'h0A12ABCDEF, "R6 select word 1");
      bank_sel = 1'b1; wait_clk(2);
      chk(ctrl_word, 40'h051100C0DE, "R6 select word 2");

      // R7 and R8 back-to-back reads
      do_read(20'hABCDE, 1'b1, 1'b0, 2'b10, 1'b0);
      do_read(20'h12345, 1'b0, 1'b1, 2'b01, 1'b0);

      // R9 busy output mode via bit 36 in word 1
      send_frame(4'b1100, 40, 40'h1000000000);
      bank_sel = 1'b0;
      ifc_busy = 1'b1; wait_clk(2);
      chk({38'b0, ser_dout_en, ser_dout}, 40'd2, "R9 busy shows 0");
      ifc_busy = 1'b0; wait_clk(2);
      chk({38'b0, ser_dout_en, ser_dout}, 40'd3, "R9 done shows 1");
      bank_sel = 1'b1; wait_clk(2);
      chk({39'b0, ser_dout_en}, 40'd0, "R10 word 2 has busy mode off");
      bank_sel = 1'b0; wait_clk(2);
      // R9 read takes priority, output stays on afterwards
      do_read(20'h0F0F0, 1'b0, 1'b1, 2'b11, 1'b1);

      summary();
      $finish;
   end
endmodule